// File: doc/BRIEF.md
# AGC Gain Freeze Controller

This controller decides whether the receive-path gain loop keeps adapting or holds its present gain. While no carrier has been detected, it leaves the loop free. The PHY raises a carrier-select input when it recognises a valid preamble. From that point the controller lets the loop keep adapting for a programmable number of ADC sample periods. It then asserts a single hold output so that the gain stays fixed for the rest of the reception. When the PHY drops carrier-select, the hold is released. A separate freeze input forces the hold at once, whatever the state of the timer.

Time is measured in ADC sample periods, and one sample period is sixteen interface clocks. The controller sees these periods as single-cycle pulses on a sample-enable input and does not count interface clocks itself. Two configuration fields set the delay:

- a delay-enable bit, which selects between a fixed default and a programmed value;
- a 6-bit offset, which forms the upper part of the 12-bit programmed delay.

Top module: `agc_frz_ctrl`

## Requirements
- R1: While rst_ni is low and freeze_i is low, hold_o is low, and it stays low after reset until one of R3, R4 or R8 asserts it.
- R2: While carrier_i is low and freeze_i is low, hold_o stays low whatever the pattern of smp_en_i.
- R3: With dly_en_i = 0, hold_o rises on the clock edge that takes the 400th smp_en_i pulse counted after the edge that first samples carrier_i high. Up to that edge it stays low.
- R4: With dly_en_i = 1, the delay is the 12-bit value whose upper 6 bits are dly_ofs_i and whose lower 6 bits are fixed at 6'b011100. This gives dly_ofs_i*64 + 28 pulses, from 28 for an offset of 0 to 4060 for an offset of 63.
- R5: Only clock edges at which smp_en_i is high advance the delay. Edges without a pulse leave the remaining delay unchanged.
- R6: hold_o stays high while carrier_i stays high. It goes low after the first clock edge that samples carrier_i low, unless freeze_i is high.
- R7: If carrier_i falls before the delay expires, no hold is produced and the count is discarded. The next rise of carrier_i starts a full delay from zero.
- R8: freeze_i drives hold_o high in the same cycle, in every state and during reset. It does not stop or restart the delay count.
- R9: hold_o returns low once freeze_i and carrier_i are both low. Lowering freeze_i while a carrier hold is in effect leaves hold_o high.
- R10: The delay settings are captured on the clock edge that first samples carrier_i high. Changes to dly_en_i or dly_ofs_i during the count or the hold have no effect until carrier_i has been low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | One-cycle pulse per ADC sample period |
| dly_en_i | input | 1 | 1 selects the programmed delay, 0 selects the 400-period default |
| dly_ofs_i | input | 6 | Upper six bits of the programmed delay |
| carrier_i | input | 1 | Carrier-select from the PHY, high after a valid preamble |
| freeze_i | input | 1 | Immediate gain freeze |
| hold_o | output | 1 | Gain hold to the adaptation logic, high = keep gain |

## Verification
The assertions check the following on every cycle:
- the latched delay always has a legal form;
- the count never reaches or passes the delay while it is running;
- the count does not move without a sample pulse;
- the latched settings do not change outside the adapt state;
- the hold is released after carrier-select and freeze are both low.

The bench scenarios are the only place where the exact pulse count before the hold appears is checked, for the default delay, for the smallest, middle and largest programmed offsets, and with sparse sample pulses. The same applies to the restart after an early carrier drop, to freeze that does not disturb the count, and to settings changed mid-count that are ignored.

// File: rtl/agc_frz_pkg.sv
package agc_frz_pkg;
  typedef enum logic [1:0] {
    ST_ADAPT = 2'd0,
    ST_COUNT = 2'd1,
    ST_LOCK  = 2'd2
  } frz_state_e;
endpackage

// File: rtl/agc_frz_limit.sv
module agc_frz_limit #(
  parameter int unsigned TMR_W   = 12,
  parameter int unsigned OFS_W   = 6,
  parameter int unsigned LOW_FIX = 28,
  parameter int unsigned DEF_DLY = 400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dly_en_i,
  input  logic [OFS_W-1:0] dly_ofs_i,
  output logic [TMR_W-1:0] limit_o
);
  localparam int unsigned LOW_W = TMR_W - OFS_W;
  localparam logic [LOW_W-1:0] LOW_BITS = LOW_W'(LOW_FIX);
  localparam logic [TMR_W-1:0] DEF_LIM  = TMR_W'(DEF_DLY);

  logic [TMR_W-1:0] limit_q, limit_d;

  assign limit_d = dly_en_i ? {dly_ofs_i, LOW_BITS} : DEF_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     limit_q <= DEF_LIM;
    else if (load_i) limit_q <= limit_d;
  end

  assign limit_o = limit_q;

  // R3 / R4: the latched delay is either the default or carries the fixed low bits
  assert_limit_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_q == DEF_LIM) || (limit_q[LOW_W-1:0] == LOW_BITS));

  // R10: settings are only taken while loading
  assert_limit_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(limit_q));
endmodule

// File: rtl/agc_frz_timer.sv
module agc_frz_timer #(
  parameter int unsigned TMR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             smp_en_i,
  input  logic [TMR_W-1:0] limit_i,
  output logic             hit_o
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + TMR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && smp_en_i) cnt_q <= cnt_inc;
  end

  // the pulse that completes the delay
  assign hit_o = run_i && smp_en_i && (cnt_inc == limit_i);

  // R5: no sample pulse, no progress
  assert_cnt_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_en_i && !clr_i) |=> $stable(cnt_q));

  // R3 / R4: a running count stays below the delay
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/agc_frz_fsm.sv
module agc_frz_fsm
  import agc_frz_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carrier_i,
  input  logic hit_i,
  output logic clr_o,
  output logic run_o,
  output logic load_o,
  output logic lock_o
);
  frz_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ADAPT: if (carrier_i) state_d = ST_COUNT;
      ST_COUNT: begin
        if (!carrier_i)  state_d = ST_ADAPT;
        else if (hit_i)  state_d = ST_LOCK;
      end
      ST_LOCK:  if (!carrier_i) state_d = ST_ADAPT;
      default:  state_d = ST_ADAPT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ADAPT;
    else         state_q <= state_d;
  end

  assign clr_o  = (state_q != ST_COUNT);
  assign run_o  = (state_q == ST_COUNT) && carrier_i;
  assign load_o = (state_q == ST_ADAPT);
  assign lock_o = (state_q == ST_LOCK);

  // R6 / R7: a low carrier always ends counting or locking
  assert_carrier_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carrier_i |=> (state_q == ST_ADAPT));

  // R3: lock is only reached from a running count
  assert_lock_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(run_o));
endmodule

// File: rtl/agc_frz_ctrl.sv
module agc_frz_ctrl #(
  parameter int unsigned TMR_W   = 12,
  parameter int unsigned OFS_W   = 6,
  parameter int unsigned LOW_FIX = 28,
  parameter int unsigned DEF_DLY = 400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_en_i,
  input  logic             dly_en_i,
  input  logic [OFS_W-1:0] dly_ofs_i,
  input  logic             carrier_i,
  input  logic             freeze_i,
  output logic             hold_o
);
  logic [TMR_W-1:0] limit;
  logic clr, run, load, lock, hit;

  agc_frz_limit #(
    .TMR_W(TMR_W), .OFS_W(OFS_W), .LOW_FIX(LOW_FIX), .DEF_DLY(DEF_DLY)
  ) u_limit (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .dly_en_i(dly_en_i), .dly_ofs_i(dly_ofs_i), .limit_o(limit)
  );

  agc_frz_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .run_i(run),
    .smp_en_i(smp_en_i), .limit_i(limit), .hit_o(hit)
  );

  agc_frz_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .carrier_i(carrier_i), .hit_i(hit),
    .clr_o(clr), .run_o(run), .load_o(load), .lock_o(lock)
  );

  // freeze bypasses all registers so it acts within the cycle
  assign hold_o = lock | freeze_i;

  // R9: both requests low releases the hold after one edge
  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!carrier_i && !freeze_i) |=> (!hold_o || freeze_i));

  // R6: a hold that is not forced by freeze follows a high carrier
  assert_hold_needs_carrier_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hold_o) && !freeze_i) |-> $past(carrier_i));
endmodule

// File: tb/agc_frz_ctrl_bench.sv
module agc_frz_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0, dly_en = 1'b0, carrier = 1'b0, freeze = 1'b0;
  logic [5:0] dly_ofs = '0;
  logic       hold;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct { bit exp; string tag; } item_t;
  item_t sb_q[$];

  // reference model state, from the requirements
  int  m_st = 0;   // 0 adapt, 1 counting, 2 holding
  int  m_cnt = 0, m_lim = 400;

  always #4 clk = ~clk;

  agc_frz_ctrl u_agc_frz_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .smp_en_i(smp_en), .dly_en_i(dly_en),
    .dly_ofs_i(dly_ofs), .carrier_i(carrier), .freeze_i(freeze), .hold_o(hold)
  );

  task automatic check(input bit exp, input string tag);
    checks++;
    if (hold !== exp) begin
      failures++;
      $display("FAIL %s: hold_o=%b expected %b at %0t", tag, hold, exp, $time);
    end
  endtask

  // monitor: compare at negedges as results appear
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.exp, it.tag);
    end
  end

  // driver: one clock per call; the model sees what the design just sampled
  task automatic step(input bit c, input bit s, input bit f, input bit de,
                      input logic [5:0] ofs, input string tag);
    item_t it;
    @(posedge clk);
    case (m_st)
      0: begin
        m_lim = dly_en ? (int'(dly_ofs) * 64 + 28) : 400;
        if (carrier) begin m_st = 1; m_cnt = 0; end
      end
      1: begin
        if (!carrier) m_st = 0;
        else if (smp_en) begin
          m_cnt++;
          if (m_cnt == m_lim) m_st = 2;
        end
      end
      default: if (!carrier) m_st = 0;
    endcase
    #1;
    carrier = c; smp_en = s; freeze = f; dly_en = de; dly_ofs = ofs;
    it.exp = (m_st == 2) || f;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic run(input int n, input bit c, input bit f, input bit de,
                     input logic [5:0] ofs, input int per, input string tag);
    for (int k = 0; k < n; k++)
      step(c, (k % per) == (per - 1), f, de, ofs, tag);
  endtask

  initial begin
    #2;
    freeze = 1'b0;
    @(negedge clk); check(1'b0, "R1 reset");
    freeze = 1'b1;
    #1; check(1'b1, "R8 freeze in reset");
    freeze = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check(1'b0, "R1 after reset");

    run(50, 0, 0, 0, 6'd0, 1, "R2");
    // default delay 400, pulses every cycle
    run(405, 1, 0, 0, 6'd0, 1, "R3");
    run(3, 0, 0, 0, 6'd0, 1, "R6");
    // programmed delays: 348, 28, 4060
    run(355, 1, 0, 1, 6'd5, 1, "R4 ofs5");
    run(2, 0, 0, 1, 6'd5, 1, "R6");
    run(35, 1, 0, 1, 6'd0, 1, "R4 ofs0");
    run(2, 0, 0, 1, 6'd0, 1, "R6");
    run(4070, 1, 0, 1, 6'd63, 1, "R4 ofs63");
    run(2, 0, 0, 1, 6'd63, 1, "R6");
    // sparse pulses, one per 16 clocks
    run(470, 1, 0, 1, 6'd0, 16, "R5");
    run(2, 0, 0, 1, 6'd0, 1, "R6");
    // early drop then full restart (delay 92)
    run(60, 1, 0, 1, 6'd1, 1, "R7 early");
    run(2, 0, 0, 1, 6'd1, 1, "R7 drop");
    run(100, 1, 0, 1, 6'd1, 1, "R7 restart");
    run(2, 0, 0, 1, 6'd1, 1, "R6");
    // freeze mid-count does not disturb the count
    run(10, 1, 0, 1, 6'd1, 1, "R8 pre");
    run(3, 1, 1, 1, 6'd1, 1, "R8 freeze");
    run(85, 1, 0, 1, 6'd1, 1, "R8 post");
    // freeze toggled while holding
    run(3, 1, 1, 1, 6'd1, 1, "R9 hold+freeze");
    run(3, 1, 0, 1, 6'd1, 1, "R9 freeze off");
    run(2, 0, 0, 1, 6'd1, 1, "R9 release");
    // freeze alone with carrier low
    run(5, 0, 1, 0, 6'd0, 1, "R8 idle freeze");
    run(4, 0, 0, 0, 6'd0, 1, "R9 idle release");
    // settings change after capture are ignored
    run(2, 1, 0, 1, 6'd0, 1, "R10 start");
    run(40, 1, 0, 0, 6'd63, 1, "R10 changed");
    run(2, 0, 0, 0, 6'd0, 1, "R6");
    @(negedge clk); @(negedge clk);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R1: scoreboard left %0d expected 0", sb_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule